// File: doc/BRIEF.md
# Oscillator Frequency Error Meter

This block measures how far a divided oscillator clock is from a commanded frequency. A start pulse opens a measurement. The block first waits for a programmable number of wait-state units, then opens a counting window of R·2^n reference-clock cycles. During that window it counts rising edges of the oscillator clock. The count is compared with the expected value V = floor(N·2^n), where N = Nint + Nfrac/2^24 is the commanded divide ratio. The block reports the raw count and a signed, saturated error word.

The oscillator side keeps a free-running counter that crosses into the reference domain as Gray code through two flops. The window opens and closes on snapshots of that synchronised value. The divided oscillator clock must therefore run slower than the reference clock. Sequencing runs on a control-clock enable equal to the reference clock divided by D, where D is 1, 4, 16 or 32. One wait-state unit is WAIT_UNIT control cycles, 100 by default. The ratio words, R, n, K and the divider select must stay stable from start until done.

Top module: `vco_freq_err`

## Requirements
- R1: After reset, `done` is 0, `err_word` is 0 and `raw_count` is 0.
- R2: `raw_count` equals the number of `clk_osc` rising edges within a window of exactly `ref_div`·2^`win_exp` reference cycles, to within one count.
- R3: `err_word` equals `raw_count` − floor((`n_int`·2^24 + `n_frac`)·2^`win_exp` / 2^24) as a two's complement value of ERR_W bits (default 20). Its top bit (bit 19 by default) is the sign.
- R4: An error above 2^(ERR_W−1)−1 reads as 2^(ERR_W−1)−1 (0x7FFFF for 20 bits).
- R5: An error below −2^(ERR_W−1) reads as −2^(ERR_W−1) (0x80000 for 20 bits).
- R6: `clk_sel` values 0, 1, 2 and 3 select a control divisor D of 1, 4, 16 and 32. `done` stays high for exactly D reference cycles after each result update.
- R7: A `start` that arrives while a measurement is in progress is ignored. Each accepted start produces exactly one `done` pulse.
- R8: Count from the reference edge that samples `start` to the edge that raises `done`. This number of cycles lies between K·WAIT_UNIT·D + W + 2 and K·WAIT_UNIT·D + W + 2·D inclusive, where W = `ref_div`·2^`win_exp` and K = `wait_k`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| clk_osc | input | 1 | Divided oscillator clock, slower than clk_ref |
| ref_div | input | RDIV_W (14) | Reference divider R, 1 to 16383 |
| win_exp | input | 3 | Window exponent n |
| n_int | input | NINT_W (16) | Integer part of the divide ratio |
| n_frac | input | FRAC_W (24) | Fractional part of the divide ratio |
| clk_sel | input | 2 | Control-clock divisor select |
| wait_k | input | 2 | Number of wait-state units K |
| start | input | 1 | Start request, sampled on clk_ref |
| err_word | output | ERR_W (20) | Saturated signed count error |
| done | output | 1 | Result-updated flag, one control cycle long |
| raw_count | output | CNT_W (24) | Oscillator edges counted in the window |

## Verification
The bench targets the edges of the arithmetic. It drives a ratio so large that the error pins at the negative limit, and a zero ratio that drives a narrow-field second instance to the positive limit. A design that wrapped instead of clamping would show a small value with the wrong sign. Runs use the shortest window (R=1, n=0 class), a fractional ratio that lands within a count of the measured value, and every divider select together with non-zero wait counts. A mistake in the window length, the wait-unit scaling or the tick alignment moves `done` outside the latency band, or changes its width away from D. A second start issued mid-window would, in a design that honoured it, give a second `done` with no request queued.

// File: rtl/vco_fe_pkg.sv
package vco_fe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OPEN = 2'd2,
        ST_RES  = 2'd3
    } meas_st_e;

    // control divisor mask: select 0,1,2,3 -> divide by 1,4,16,32
    function automatic logic [4:0] sel_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    sel_mask = 5'd0;
            2'd1:    sel_mask = 5'd3;
            2'd2:    sel_mask = 5'd15;
            default: sel_mask = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/vco_fe_tick.sv
module vco_fe_tick
    import vco_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [4:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 5'd1;
        tick  = ((cnt_q & sel_mask(sel)) == sel_mask(sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/vco_fe_osc_sync.sv
module vco_fe_osc_sync #(
    parameter int CNT_W = 24
) (
    input  logic             clk_osc,
    input  logic             clk_ref,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_ref
);
    typedef struct packed {
        logic [CNT_W-1:0] bin;
        logic [CNT_W-1:0] gray;
    } osc_t;

    typedef struct packed {
        logic [CNT_W-1:0] s1;
        logic [CNT_W-1:0] s2;
    } ref_t;

    osc_t o_d, o_q;
    ref_t r_d, r_q;
    logic [CNT_W-1:0] s1_q;

    always_comb begin
        o_d.bin  = o_q.bin + CNT_W'(1);
        o_d.gray = o_d.bin ^ (o_d.bin >> 1);
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    always_comb begin
        r_d.s1 = o_q.gray;
        r_d.s2 = r_q.s1;
        s1_q   = r_q.s1;
        count_ref[CNT_W-1] = r_q.s2[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            count_ref[i] = count_ref[i+1] ^ r_q.s2[i];
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/vco_fe_calc.sv
module vco_fe_calc #(
    parameter int NINT_W = 16,
    parameter int FRAC_W = 24,
    parameter int CNT_W  = 24,
    parameter int ERR_W  = 20
) (
    input  logic [NINT_W-1:0] n_int,
    input  logic [FRAC_W-1:0] n_frac,
    input  logic [2:0]        win_exp,
    input  logic [CNT_W-1:0]  raw,
    output logic [ERR_W-1:0]  err
);
    localparam int RAT_W  = NINT_W + FRAC_W;
    localparam int SH_W   = RAT_W + 7;
    localparam int V_W    = SH_W - FRAC_W;
    localparam int DIFF_W = ((CNT_W > V_W) ? CNT_W : V_W) + 2;

    logic [SH_W-1:0]          shifted;
    logic [V_W-1:0]           exp_v;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] max_pos;
    logic signed [DIFF_W-1:0] min_neg;

    always_comb begin
        shifted = SH_W'({n_int, n_frac}) << win_exp;
        exp_v   = shifted[SH_W-1:FRAC_W];
        diff    = $signed(DIFF_W'(raw)) - $signed(DIFF_W'(exp_v));
        max_pos = $signed(DIFF_W'((64'd1 << (ERR_W - 1)) - 64'd1));
        min_neg = -max_pos - DIFF_W'(1);
        if (diff > max_pos)      err = max_pos[ERR_W-1:0];
        else if (diff < min_neg) err = min_neg[ERR_W-1:0];
        else                     err = diff[ERR_W-1:0];
    end
endmodule

// File: rtl/vco_freq_err.sv
module vco_freq_err
    import vco_fe_pkg::*;
#(
    parameter int RDIV_W    = 14,
    parameter int NINT_W    = 16,
    parameter int FRAC_W    = 24,
    parameter int CNT_W     = 24,
    parameter int ERR_W     = 20,
    parameter int WAIT_UNIT = 100
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              clk_osc,
    input  logic [RDIV_W-1:0] ref_div,
    input  logic [2:0]        win_exp,
    input  logic [NINT_W-1:0] n_int,
    input  logic [FRAC_W-1:0] n_frac,
    input  logic [1:0]        clk_sel,
    input  logic [1:0]        wait_k,
    input  logic              start,
    output logic [ERR_W-1:0]  err_word,
    output logic              done,
    output logic [CNT_W-1:0]  raw_count
);
    localparam int WIN_W = RDIV_W + 8;
    localparam int WC_W  = $clog2(3 * WAIT_UNIT + 1);

    typedef struct packed {
        meas_st_e         st;
        logic             pend;
        logic [WC_W-1:0]  wcnt;
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] snap0;
        logic [CNT_W-1:0] snap1;
        logic [CNT_W-1:0] raw;
        logic [ERR_W-1:0] err;
        logic             done;
    } ctl_t;

    ctl_t d, q;

    logic             tick;
    logic [CNT_W-1:0] osc_cnt;
    logic [CNT_W-1:0] span;
    logic [ERR_W-1:0] calc_err;
    logic [WIN_W-1:0] win_load;
    logic [WC_W-1:0]  wait_load;

    vco_fe_tick i_tick (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .tick  (tick)
    );

    vco_fe_osc_sync #(.CNT_W(CNT_W)) i_sync (
        .clk_osc   (clk_osc),
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .count_ref (osc_cnt)
    );

    vco_fe_calc #(
        .NINT_W (NINT_W),
        .FRAC_W (FRAC_W),
        .CNT_W  (CNT_W),
        .ERR_W  (ERR_W)
    ) i_calc (
        .n_int   (n_int),
        .n_frac  (n_frac),
        .win_exp (win_exp),
        .raw     (span),
        .err     (calc_err)
    );

    always_comb begin
        span      = q.snap1 - q.snap0;
        win_load  = (WIN_W'(ref_div) << win_exp) - WIN_W'(1);
        wait_load = WC_W'(wait_k) * WC_W'(WAIT_UNIT) - WC_W'(1);
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) d.pend = 1'b1;
                if (tick) begin
                    d.done = 1'b0;
                    if (q.pend) begin
                        d.pend = 1'b0;
                        if (wait_k == 2'd0) begin
                            d.st    = ST_OPEN;
                            d.snap0 = osc_cnt;
                            d.win   = win_load;
                        end else begin
                            d.st   = ST_WAIT;
                            d.wcnt = wait_load;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    if (q.wcnt == '0) begin
                        d.st    = ST_OPEN;
                        d.snap0 = osc_cnt;
                        d.win   = win_load;
                    end else begin
                        d.wcnt = q.wcnt - WC_W'(1);
                    end
                end
            end
            ST_OPEN: begin
                if (q.win == '0) begin
                    d.st    = ST_RES;
                    d.snap1 = osc_cnt;
                end else begin
                    d.win = q.win - WIN_W'(1);
                end
            end
            default: begin
                if (tick) begin
                    d.raw  = span;
                    d.err  = calc_err;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
        endcase
        err_word  = q.err;
        raw_count = q.raw;
        done      = q.done;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/vco_freq_err_chk.sv
module vco_freq_err_chk
    import vco_fe_pkg::*;
#(
    parameter int RDIV_W = 14,
    parameter int CNT_W  = 24,
    parameter int ERR_W  = 20
) (
    input logic              clk_ref,
    input logic              rst_n,
    input logic              tick,
    input meas_st_e          st,
    input logic              done,
    input logic [ERR_W-1:0]  err_word,
    input logic [CNT_W-1:0]  raw_count,
    input logic [CNT_W-1:0]  span,
    input logic [CNT_W-1:0]  gray_s1,
    input logic [RDIV_W-1:0] ref_div,
    input logic [2:0]        win_exp
);
    localparam int LEN_W = RDIV_W + 9;
    logic [LEN_W-1:0] open_len;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)              open_len <= '0;
        else if (st == ST_OPEN)  open_len <= open_len + LEN_W'(1);
        else                     open_len <= '0;
    end

    // R6
    done_drop_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (done && tick) |=> !done);

    // R6
    done_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (done && !tick) |=> done);

    // R8
    window_len_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st == ST_RES && $past(st) == ST_OPEN) |-> (open_len == (LEN_W'(ref_div) << win_exp)));

    // R2
    gray_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $countones(gray_s1 ^ $past(gray_s1)) <= 1);

    // R2
    raw_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$rose(done) |-> $stable(raw_count));

    // R3
    raw_latch_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(done) |-> (raw_count == span));

    // R7
    one_result_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(done) |-> $past(st) == ST_RES);

    // R7
    no_rewait_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st == ST_OPEN) |=> (st != ST_WAIT && st != ST_IDLE));

    // R1
    err_zero_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!done && $stable(raw_count) && $past(raw_count) == '0 && $past(err_word) == '0) |-> err_word == '0);
endmodule

bind vco_freq_err vco_freq_err_chk #(
    .RDIV_W (RDIV_W),
    .CNT_W  (CNT_W),
    .ERR_W  (ERR_W)
) i_chk (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .tick      (tick),
    .st        (q.st),
    .done      (done),
    .err_word  (err_word),
    .raw_count (raw_count),
    .span      (span),
    .gray_s1   (i_sync.s1_q),
    .ref_div   (ref_div),
    .win_exp   (win_exp)
);

// File: tb/test_vco_freq_err.sv
module test_vco_freq_err;
    localparam int TCLK = 10;
    localparam int TOSC = 14;
    localparam int UNIT = 100;

    logic        clk = 1'b0;
    logic        clk_osc = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ref_div = 14'd1;
    logic [2:0]  win_exp = 3'd0;
    logic [15:0] n_int = '0;
    logic [23:0] n_frac = '0;
    logic [1:0]  clk_sel = '0;
    logic [1:0]  wait_k = '0;
    logic        start = 1'b0;
    logic [19:0] err_word;
    logic        done;
    logic [23:0] raw_count;
    logic [11:0] err_nar;
    logic        done_nar;
    logic [23:0] raw_nar;

    typedef struct {
        longint r; longint n; longint ni; longint nf;
        longint k; longint dv; longint t0;
    } item_t;

    item_t  sb[$];
    item_t  cur;
    int     n_chk = 0;
    int     n_bad = 0;
    int     n_push = 0;
    int     n_done = 0;
    longint cyc = 0;
    int     hi_len = 0;
    logic   done_prev = 1'b0;

    always #(TCLK/2) clk = ~clk;
    initial begin
        #1;
        forever #(TOSC/2) clk_osc = ~clk_osc;
    end
    always @(posedge clk) cyc = cyc + 1;

    vco_freq_err i_vco_freq_err (
        .clk_ref(clk), .rst_n(rst_n), .clk_osc(clk_osc), .ref_div(ref_div),
        .win_exp(win_exp), .n_int(n_int), .n_frac(n_frac), .clk_sel(clk_sel),
        .wait_k(wait_k), .start(start), .err_word(err_word), .done(done),
        .raw_count(raw_count)
    );

    vco_freq_err #(.ERR_W(12)) i_vco_freq_err_nar (
        .clk_ref(clk), .rst_n(rst_n), .clk_osc(clk_osc), .ref_div(ref_div),
        .win_exp(win_exp), .n_int(n_int), .n_frac(n_frac), .clk_sel(clk_sel),
        .wait_k(wait_k), .start(start), .err_word(err_nar), .done(done_nar),
        .raw_count(raw_nar)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint diff, input int w);
        longint mx = (longint'(1) << (w - 1)) - 1;
        longint v = diff;
        if (v > mx) v = mx;
        if (v < -mx - 1) v = -mx - 1;
        return v & ((longint'(1) << w) - 1);
    endfunction

    // monitor: pops expected items when done rises
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && !done_prev) begin
                longint w, v, lo, hi, lat;
                n_done++;
                hi_len = 1;
                if (sb.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    cur = sb.pop_front();
                    w   = cur.r << cur.n;
                    v   = (((cur.ni << 24) | cur.nf) << cur.n) >> 24;
                    // R2 raw count within one of ideal
                    check((longint'(raw_count) * TOSC >= w * TCLK - TOSC) &&
                          (longint'(raw_count) * TOSC <= w * TCLK + TOSC),
                          "R2 raw", raw_count, (w * TCLK) / TOSC);
                    // R3 error word, R4/R5 saturation at 20 bits
                    check(longint'(err_word) == sat(longint'(raw_count) - v, 20),
                          "R3/R4/R5 err", err_word, sat(longint'(raw_count) - v, 20));
                    // R4/R5 saturation at 12 bits
                    check(done_nar && longint'(err_nar) == sat(longint'(raw_nar) - v, 12),
                          "R4/R5 narrow err", err_nar, sat(longint'(raw_nar) - v, 12));
                    // R8 latency band
                    lat = cyc - cur.t0;
                    lo  = cur.k * UNIT * cur.dv + w + 2;
                    hi  = cur.k * UNIT * cur.dv + w + 2 * cur.dv;
                    check(lat >= lo && lat <= hi, "R8 latency", lat, lo);
                end
            end else if (done) begin
                hi_len++;
            end else if (done_prev) begin
                // R6 done width equals control divisor
                check(longint'(hi_len) == cur.dv, "R6 done width", hi_len, cur.dv);
            end
            done_prev = done;
        end
    end

    task automatic measure(input int r, input int n, input longint ni, input longint nf,
                           input int k, input int sel, input bit extra_start);
        item_t it;
        @(negedge clk);
        ref_div = 14'(r); win_exp = 3'(n); n_int = 16'(ni); n_frac = 24'(nf);
        wait_k = 2'(k); clk_sel = 2'(sel);
        @(negedge clk);
        it.r = r; it.n = n; it.ni = ni; it.nf = nf; it.k = k;
        it.dv = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 16 : 32;
        it.t0 = cyc + 1;
        sb.push_back(it);
        n_push++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            // R7: second request while busy
            repeat (it.dv * 3 + 40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (n_done < n_push) @(negedge clk);
        repeat (2 * it.dv + 4) @(negedge clk);
        if (extra_start) begin
            repeat ((r << n) + k * UNIT * it.dv + 200) @(negedge clk);
            check(n_done == n_push, "R7 single done", n_done, n_push);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done", done, 0);
        check(err_word == '0, "R1 err", err_word, 0);
        check(raw_count == '0, "R1 raw", raw_count, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(done == 1'b0 && raw_count == '0, "R1 idle", done, 0);

        measure(4, 3, 20, 0, 0, 0, 1'b0);
        measure(50, 5, 35, 24'hB6DB6D, 1, 1, 1'b0);
        measure(1, 7, 0, 24'hB6DB6D, 2, 2, 1'b0);
        measure(3, 0, 2, 0, 3, 3, 1'b0);
        measure(1, 0, 0, 0, 0, 2, 1'b0);
        measure(2, 7, 16'hFFFF, 24'hFFFFFF, 0, 0, 1'b0);
        measure(200, 5, 0, 0, 0, 1, 1'b0);
        measure(100, 4, 71, 24'h6DB6DB, 1, 1, 1'b1);

        check(sb.size() == 0, "R7 queue drained", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule